// File: doc/BRIEF.md
# DMA Channel Sequencer with Event Outputs and Graceful Abort

This block moves a small set of DMA channels through block transfers. Each block is a count of beats grouped into bursts. A channel is loaded from a descriptor that is presented on parallel input ports. Only one channel owns the memory-side interface at a time. Each beat is one request/done handshake on that interface. The channel keeps the interface for one burst and then gives it back to a fixed lowest-index-first arbiter. When a block completes, a per-channel link input decides what happens next: either the descriptor now on the ports is loaded and the chain continues, or the channel switches itself off.

Each descriptor selects when its channel emits a one-cycle event pulse: after every beat, after every burst, after block completion, or never. Events leave the block only if two conditions hold: the channel's event output enable is set, and the channel was built with event support.

Software can abort one channel, or disable the whole controller. A channel that is in the middle of a beat always finishes that beat and its write-back first. Channels that are enabled but not moving stop on the next clock. Enable status outputs report when each channel, and the controller as a whole, has actually stopped.

Top module: `dmaevt_ctrl`

## Requirements
- R1: An event pulse on `evt_o[c]` is high for exactly one cycle. It appears in the cycle after the done handshake of the beat that caused it. At most one channel pulses in any cycle.
- R2: The descriptor event select field is 2 bits: 0 = no events, 1 = beat, 2 = burst, 3 = block. With select 1, a block of B beats gives exactly B pulses.
- R3: With select 2, a pulse is produced each time the burst length is reached, and also at the end of the block. A block of B beats with burst length L gives ceil(B/L) pulses.
- R4: With select 3, exactly one pulse is produced when a block completes its full beat count. In a chain, only the descriptors that carry select 3 produce a pulse.
- R5: A channel pulses only while its `ch_evoe_i` bit is set. A channel whose `EVT_CAP` bit is 0 (by default the highest index) never pulses.
- R6: Among channels that are enabled and requesting, the lowest index wins. The winner keeps the interface until its burst ends, its block ends, or it is stopped.
- R7: Aborting a channel that is not active clears its `ch_en_o` bit in the next cycle. Aborting the active channel lets the beat in flight finish. No further beat is issued. One write-back follows, and after that the bit clears.
- R8: Once `mem_req_o` is raised, it stays high with stable `mem_addr_o` and `mem_ch_o` until `mem_done_i` is seen, even across an abort or a disable.
- R9: After a controller disable request, every enabled channel that is not active shows `ch_en_o` low in the next cycle. No new beat is started.
- R10: The active channel stays enabled through its current beat and its write-back cycle, and both it and `ctl_en_o` clear together at the end of that cycle. If no channel is active, `ctl_en_o` clears in the cycle after the request. No channel is ever enabled while `ctl_en_o` is low.
- R11: Write-back is a one-cycle `wb_valid_o` in the cycle after the final beat of a completed or stopped block. It stores that channel's remaining beat count and next address into `wb_remain_o` and `wb_addr_o`.
- R12: At block completion, a set link bit reloads the channel from the descriptor ports and keeps it enabled. A clear link bit disables the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_enable_i | input | 1 | Pulse: enable the controller |
| ctl_disable_i | input | 1 | Pulse: request a graceful controller disable |
| ch_start_i | input | NCH | Pulse per channel: load the descriptor and enable the channel |
| ch_abort_i | input | NCH | Pulse per channel: request the channel to stop |
| ch_req_i | input | NCH | Per-channel transfer request level |
| ch_evoe_i | input | NCH | Per-channel event output enable |
| desc_beats_i | input | NCH*CNT_W | Beats per block, per channel (at least 1) |
| desc_burst_i | input | NCH*CNT_W | Beats per burst, per channel (at least 1) |
| desc_addr_i | input | NCH*ADDR_W | Start address, per channel |
| desc_evsel_i | input | NCH*2 | Event select, per channel |
| desc_link_i | input | NCH | Continue with the descriptor on the ports at block end |
| mem_req_o | output | 1 | Beat request to the memory side |
| mem_addr_o | output | ADDR_W | Beat address |
| mem_ch_o | output | IDX_W | Channel that owns the beat |
| mem_done_i | input | 1 | Beat completion strobe |
| evt_o | output | NCH | One-cycle event pulses |
| ch_en_o | output | NCH | Channel enable status |
| ctl_en_o | output | 1 | Controller enable status |
| wb_valid_o | output | 1 | Write-back strobe |
| wb_ch_o | output | IDX_W | Channel being written back |
| wb_remain_o | output | NCH*CNT_W | Stored remaining beat count per channel |
| wb_addr_o | output | NCH*ADDR_W | Stored next address per channel |

## Verification
The bench counts event pulses in each select mode. A design that mixed up the burst and block selects would give the wrong count, and so would one that dropped the pulse for the final partial burst or failed to gate on the enable or capability bit. For aborts, the memory model is stalled in the middle of a beat while the abort or disable arrives. A design that cut the handshake, disabled the active channel too early or issued another beat would show a falling request, an early status drop or an extra logged beat. Idle channels are checked exactly one cycle after a controller disable, which catches a design that waits for the active channel before it drops the idle ones. Chained descriptors and two-channel priority are checked by logging the order in which beats complete.

// File: rtl/dmaevt_pkg.sv
package dmaevt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BEAT = 2'd1,
        ST_WB   = 2'd2
    } seq_state_e;

    localparam logic [1:0] EVSEL_NONE  = 2'd0;
    localparam logic [1:0] EVSEL_BEAT  = 2'd1;
    localparam logic [1:0] EVSEL_BURST = 2'd2;
    localparam logic [1:0] EVSEL_BLOCK = 2'd3;

endpackage

// File: rtl/dmaevt_arbiter.sv
module dmaevt_arbiter #(
    parameter int NCH   = 4,
    parameter int IDX_W = 2
) (
    input  logic [NCH-1:0]   ready_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o
);
    // lowest index has priority: scan downward so the lowest hit wins
    always_comb begin
        valid_o = |ready_i;
        idx_o   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (ready_i[i]) begin
                idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/dmaevt_event_gen.sv
module dmaevt_event_gen
    import dmaevt_pkg::*;
#(
    parameter int             NCH     = 4,
    parameter int             IDX_W   = 2,
    parameter logic [NCH-1:0] EVT_CAP = '1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stb_beat_i,
    input  logic                stb_burst_i,
    input  logic                stb_block_i,
    input  logic [IDX_W-1:0]    act_i,
    input  logic [NCH-1:0][1:0] evsel_i,
    input  logic [NCH-1:0]      evoe_i,
    output logic [NCH-1:0]      evt_o
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        if (EVT_CAP[c]) begin : g_cap
            logic hit_d, hit_q;
            always_comb begin
                hit_d = 1'b0;
                if (act_i == IDX_W'(c) && evoe_i[c]) begin
                    unique case (evsel_i[c])
                        EVSEL_BEAT:  hit_d = stb_beat_i;
                        EVSEL_BURST: hit_d = stb_burst_i;
                        EVSEL_BLOCK: hit_d = stb_block_i;
                        default:     hit_d = 1'b0;
                    endcase
                end
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) hit_q <= 1'b0;
                else        hit_q <= hit_d;
            end
            assign evt_o[c] = hit_q;
        end else begin : g_nocap
            logic unused_nocap;
            assign unused_nocap = ^{evsel_i[c], evoe_i[c]};
            assign evt_o[c]     = 1'b0;
        end
    end
endmodule

// File: rtl/dmaevt_wb_store.sv
module dmaevt_wb_store #(
    parameter int NCH    = 4,
    parameter int IDX_W  = 2,
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_i,
    input  logic [IDX_W-1:0]      ch_i,
    input  logic [CNT_W-1:0]      remain_i,
    input  logic [ADDR_W-1:0]     addr_i,
    output logic [NCH*CNT_W-1:0]  remain_o,
    output logic [NCH*ADDR_W-1:0] addr_o
);
    for (genvar c = 0; c < NCH; c++) begin : g_slot
        logic [CNT_W-1:0]  rem_d, rem_q;
        logic [ADDR_W-1:0] adr_d, adr_q;
        always_comb begin
            rem_d = rem_q;
            adr_d = adr_q;
            if (wr_i && ch_i == IDX_W'(c)) begin
                rem_d = remain_i;
                adr_d = addr_i;
            end
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rem_q <= '0;
                adr_q <= '0;
            end else begin
                rem_q <= rem_d;
                adr_q <= adr_d;
            end
        end
        assign remain_o[c*CNT_W +: CNT_W]  = rem_q;
        assign addr_o[c*ADDR_W +: ADDR_W]  = adr_q;
    end
endmodule

// File: rtl/dmaevt_ctrl.sv
module dmaevt_ctrl
    import dmaevt_pkg::*;
#(
    parameter int             NCH     = 4,
    parameter int             CNT_W   = 8,
    parameter int             ADDR_W  = 16,
    parameter logic [NCH-1:0] EVT_CAP = {1'b0, {(NCH-1){1'b1}}},
    localparam int            IDX_W   = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ctl_enable_i,
    input  logic                  ctl_disable_i,
    input  logic [NCH-1:0]        ch_start_i,
    input  logic [NCH-1:0]        ch_abort_i,
    input  logic [NCH-1:0]        ch_req_i,
    input  logic [NCH-1:0]        ch_evoe_i,
    input  logic [NCH*CNT_W-1:0]  desc_beats_i,
    input  logic [NCH*CNT_W-1:0]  desc_burst_i,
    input  logic [NCH*ADDR_W-1:0] desc_addr_i,
    input  logic [NCH*2-1:0]      desc_evsel_i,
    input  logic [NCH-1:0]        desc_link_i,
    output logic                  mem_req_o,
    output logic [ADDR_W-1:0]     mem_addr_o,
    output logic [IDX_W-1:0]      mem_ch_o,
    input  logic                  mem_done_i,
    output logic [NCH-1:0]        evt_o,
    output logic [NCH-1:0]        ch_en_o,
    output logic                  ctl_en_o,
    output logic                  wb_valid_o,
    output logic [IDX_W-1:0]      wb_ch_o,
    output logic [NCH*CNT_W-1:0]  wb_remain_o,
    output logic [NCH*ADDR_W-1:0] wb_addr_o
);
    typedef struct packed {
        seq_state_e                    st;
        logic [IDX_W-1:0]              act;
        logic                          ctl_en;
        logic                          dis_pend;
        logic [NCH-1:0]                en;
        logic [NCH-1:0]                abt;
        logic [NCH-1:0][CNT_W-1:0]     remain;
        logic [NCH-1:0][CNT_W-1:0]     burst_len;
        logic [NCH-1:0][CNT_W-1:0]     burst_cnt;
        logic [NCH-1:0][ADDR_W-1:0]    addr;
        logic [NCH-1:0][1:0]           evsel;
    } seq_t;

    seq_t q, d;

    logic             stb_beat, stb_burst, stb_block, wb_fire;
    logic [NCH-1:0]   ready, load;
    logic             grant_v;
    logic [IDX_W-1:0] grant_idx;
    logic             busy, dis_now, stop, kill;
    logic [CNT_W-1:0] rem_nx, bc_nx;

    // candidates for the next burst: enabled, requesting, not being aborted
    assign ready = q.en & ch_req_i & ~ch_abort_i;

    dmaevt_arbiter #(.NCH(NCH), .IDX_W(IDX_W)) u_arb (
        .ready_i (ready),
        .valid_o (grant_v),
        .idx_o   (grant_idx)
    );

    always_comb begin
        d         = q;
        load      = '0;
        stb_beat  = 1'b0;
        stb_burst = 1'b0;
        stb_block = 1'b0;
        wb_fire   = 1'b0;
        stop      = 1'b0;
        kill      = 1'b0;
        rem_nx    = '0;
        bc_nx     = '0;
        busy      = (q.st != ST_IDLE);
        dis_now   = ctl_disable_i && q.ctl_en && !q.dis_pend;

        if (ctl_enable_i && !q.ctl_en) begin
            d.ctl_en = 1'b1;
        end

        // software start and per-channel abort
        for (int c = 0; c < NCH; c++) begin
            if (ch_start_i[c] && q.ctl_en && !q.dis_pend && !dis_now && !q.en[c]) begin
                d.en[c] = 1'b1;
                load[c] = 1'b1;
            end
            if (ch_abort_i[c] && q.en[c]) begin
                if (busy && q.act == IDX_W'(c)) d.abt[c] = 1'b1;
                else                            d.en[c]  = 1'b0;
            end
        end

        // controller disable: idle channels drop now, the active one later
        if (dis_now) begin
            d.dis_pend = 1'b1;
            for (int c = 0; c < NCH; c++) begin
                if (!(busy && q.act == IDX_W'(c))) d.en[c] = 1'b0;
            end
            if (!busy) begin
                d.ctl_en   = 1'b0;
                d.dis_pend = 1'b0;
            end
        end

        unique case (q.st)
            ST_IDLE: begin
                if (grant_v && q.ctl_en && !q.dis_pend && !dis_now) begin
                    d.st  = ST_BEAT;
                    d.act = grant_idx;
                end
            end
            ST_BEAT: begin
                if (mem_done_i) begin
                    stb_beat           = 1'b1;
                    rem_nx             = q.remain[q.act] - CNT_W'(1);
                    bc_nx              = q.burst_cnt[q.act] + CNT_W'(1);
                    d.remain[q.act]    = rem_nx;
                    d.addr[q.act]      = q.addr[q.act] + ADDR_W'(1);
                    d.burst_cnt[q.act] = bc_nx;
                    stop = q.abt[q.act] || ch_abort_i[q.act] || q.dis_pend || dis_now;
                    if (rem_nx == '0 || bc_nx == q.burst_len[q.act]) begin
                        stb_burst          = 1'b1;
                        d.burst_cnt[q.act] = '0;
                    end
                    if (rem_nx == '0) begin
                        stb_block = 1'b1;
                    end
                    if (rem_nx == '0 || stop) begin
                        d.st = ST_WB;
                    end else if (bc_nx == q.burst_len[q.act]) begin
                        d.st = ST_IDLE;
                    end
                end
            end
            ST_WB: begin
                wb_fire        = 1'b1;
                d.st           = ST_IDLE;
                d.abt[q.act]   = 1'b0;
                kill = q.abt[q.act] || ch_abort_i[q.act] || q.dis_pend || dis_now;
                if (kill) begin
                    d.en[q.act] = 1'b0;
                end else if (q.remain[q.act] == '0) begin
                    if (desc_link_i[q.act]) load[q.act] = 1'b1;
                    else                    d.en[q.act] = 1'b0;
                end
                if (q.dis_pend || dis_now) begin
                    d.ctl_en   = 1'b0;
                    d.dis_pend = 1'b0;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        // descriptor loads from the parallel ports
        for (int c = 0; c < NCH; c++) begin
            if (load[c]) begin
                d.remain[c]    = desc_beats_i[c*CNT_W +: CNT_W];
                d.burst_len[c] = desc_burst_i[c*CNT_W +: CNT_W];
                d.burst_cnt[c] = '0;
                d.addr[c]      = desc_addr_i[c*ADDR_W +: ADDR_W];
                d.evsel[c]     = desc_evsel_i[c*2 +: 2];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    dmaevt_event_gen #(.NCH(NCH), .IDX_W(IDX_W), .EVT_CAP(EVT_CAP)) u_evt (
        .clk         (clk),
        .rst_n       (rst_n),
        .stb_beat_i  (stb_beat),
        .stb_burst_i (stb_burst),
        .stb_block_i (stb_block),
        .act_i       (q.act),
        .evsel_i     (q.evsel),
        .evoe_i      (ch_evoe_i),
        .evt_o       (evt_o)
    );

    dmaevt_wb_store #(.NCH(NCH), .IDX_W(IDX_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_wb (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (wb_fire),
        .ch_i     (q.act),
        .remain_i (q.remain[q.act]),
        .addr_i   (q.addr[q.act]),
        .remain_o (wb_remain_o),
        .addr_o   (wb_addr_o)
    );

    assign mem_req_o  = (q.st == ST_BEAT);
    assign mem_addr_o = q.addr[q.act];
    assign mem_ch_o   = q.act;
    assign ch_en_o    = q.en;
    assign ctl_en_o   = q.ctl_en;
    assign wb_valid_o = (q.st == ST_WB);
    assign wb_ch_o    = q.act;

endmodule

// File: rtl/dmaevt_checker.sv
module dmaevt_checker #(
    parameter int             NCH     = 4,
    parameter int             IDX_W   = 2,
    parameter int             ADDR_W  = 16,
    parameter logic [NCH-1:0] EVT_CAP = '1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_disable_i,
    input logic [NCH-1:0]    ch_evoe_i,
    input logic              mem_req_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [IDX_W-1:0]  mem_ch_o,
    input logic              mem_done_i,
    input logic [NCH-1:0]    evt_o,
    input logic [NCH-1:0]    ch_en_o,
    input logic              ctl_en_o,
    input logic              wb_valid_o
);
    for (genvar c = 0; c < NCH; c++) begin : g_ev
        AST_EVT_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
            evt_o[c] |-> $past(mem_done_i)); // R1
        AST_EVT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
            evt_o[c] |-> (EVT_CAP[c] && $past(ch_evoe_i[c]))); // R5
    end

    AST_EVT_SINGLE_CH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(evt_o)); // R1

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_done_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_ch_o))); // R8

    AST_DIS_IDLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_disable_i && ctl_en_o && !mem_req_o && !wb_valid_o) |=> (ch_en_o == '0 && !ctl_en_o)); // R9

    AST_NO_NEW_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_disable_i && ctl_en_o) |=> !$rose(mem_req_o)); // R9

    AST_ACTIVE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> ch_en_o[mem_ch_o]); // R10

    AST_CH_NEEDS_CTL: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_en_o) |-> ctl_en_o); // R10

    AST_WB_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid_o |-> ($past(mem_done_i) && $past(mem_req_o))); // R11

    AST_WB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid_o |=> !wb_valid_o); // R11
endmodule

bind dmaevt_ctrl dmaevt_checker #(
    .NCH(NCH), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .EVT_CAP(EVT_CAP)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctl_disable_i (ctl_disable_i),
    .ch_evoe_i     (ch_evoe_i),
    .mem_req_o     (mem_req_o),
    .mem_addr_o    (mem_addr_o),
    .mem_ch_o      (mem_ch_o),
    .mem_done_i    (mem_done_i),
    .evt_o         (evt_o),
    .ch_en_o       (ch_en_o),
    .ctl_en_o      (ctl_en_o),
    .wb_valid_o    (wb_valid_o)
);

// File: tb/dmaevt_ctrl_bench.sv
`timescale 1ns/1ps
module dmaevt_ctrl_bench;
    localparam int NCH = 4, CNT_W = 8, ADDR_W = 16, IDX_W = 2, LAT = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ctl_enable = 0, ctl_disable = 0;
    logic [NCH-1:0] ch_start = '0, ch_abort = '0, ch_req = '0, ch_evoe = '0, link = '0;
    logic [NCH*CNT_W-1:0] d_beats = '0, d_burst = '0;
    logic [NCH*ADDR_W-1:0] d_addr = '0;
    logic [NCH*2-1:0] d_evsel = '0;
    logic mem_req, mem_done = 1'b0, wb_valid, ctl_en;
    logic [ADDR_W-1:0] mem_addr;
    logic [IDX_W-1:0] mem_ch, wb_ch;
    logic [NCH-1:0] evt, ch_en;
    logic [NCH*CNT_W-1:0] wb_remain;
    logic [NCH*ADDR_W-1:0] wb_addr;

    int checks = 0, errors = 0;
    int evcnt [NCH];
    int beats [NCH];
    int wbcnt = 0, ev_wide = 0, ev_early = 0, nlog = 0, mcnt = 0;
    int blog [64];
    logic [NCH-1:0] evt_prev = '0;
    logic mem_hold = 1'b0;

    always #4 clk = ~clk;

    dmaevt_ctrl #(.NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_dmaevt_ctrl (
        .clk(clk), .rst_n(rst_n), .ctl_enable_i(ctl_enable), .ctl_disable_i(ctl_disable),
        .ch_start_i(ch_start), .ch_abort_i(ch_abort), .ch_req_i(ch_req), .ch_evoe_i(ch_evoe),
        .desc_beats_i(d_beats), .desc_burst_i(d_burst), .desc_addr_i(d_addr),
        .desc_evsel_i(d_evsel), .desc_link_i(link), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
        .mem_ch_o(mem_ch), .mem_done_i(mem_done), .evt_o(evt), .ch_en_o(ch_en),
        .ctl_en_o(ctl_en), .wb_valid_o(wb_valid), .wb_ch_o(wb_ch),
        .wb_remain_o(wb_remain), .wb_addr_o(wb_addr)
    );

    initial begin
        for (int c = 0; c < NCH; c++) begin evcnt[c] = 0; beats[c] = 0; end
    end

    // memory model and output monitors, all at the falling edge
    always @(negedge clk) begin
        for (int c = 0; c < NCH; c++) begin
            if (evt[c]) begin
                evcnt[c]++;
                if (evt_prev[c]) ev_wide++;
                if (!mem_done) ev_early++;
            end
        end
        evt_prev = evt;
        if (wb_valid) wbcnt++;
        if (!rst_n) begin
            mem_done = 1'b0; mcnt = 0;
        end else if (mem_done) begin
            mem_done = 1'b0; mcnt = 0;
        end else if (mem_req && !mem_hold) begin
            if (mcnt == LAT - 1) begin
                mem_done = 1'b1;
                beats[mem_ch]++;
                if (nlog < 64) begin blog[nlog] = int'(mem_ch); nlog++; end
            end else begin
                mcnt++;
            end
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete (actual hung, expected finish)");
        summary();
        $finish;
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_desc(input int c, input int nb, input int bl, input int adr, input int sel);
        d_beats[c*CNT_W +: CNT_W]   = CNT_W'(nb);
        d_burst[c*CNT_W +: CNT_W]   = CNT_W'(bl);
        d_addr[c*ADDR_W +: ADDR_W]  = ADDR_W'(adr);
        d_evsel[c*2 +: 2]           = 2'(sel);
    endtask

    task automatic pulse_start(input logic [NCH-1:0] m);
        ch_start = m; step(); ch_start = '0;
    endtask

    task automatic pulse_ctl_en();
        ctl_enable = 1'b1; step(); ctl_enable = 1'b0;
    endtask

    task automatic wait_off(input logic [NCH-1:0] m);
        for (int i = 0; i < 2000 && (ch_en & m) != '0; i++) step();
    endtask

    task automatic wait_beats(input int c, input int n);
        for (int i = 0; i < 2000 && beats[c] < n; i++) step();
    endtask

    task automatic t_reset();
        chk(ch_en == '0 && !ctl_en, "R10", "reset status", int'(ch_en), 0);
        chk(!mem_req && !wb_valid && evt == '0, "R1", "reset outputs idle", int'(evt), 0);
        chk(wb_remain == '0, "R11", "reset write-back store", int'(wb_remain), 0);
    endtask

    task automatic t_beat_events();
        int e0 = evcnt[0];
        ch_evoe = '1; set_desc(0, 5, 2, 'h100, 1); link = '0;
        pulse_start(4'b0001); ch_req[0] = 1'b1;
        wait_off(4'b0001); ch_req[0] = 1'b0;
        chk(evcnt[0] - e0 == 5, "R2", "beat-mode pulses", evcnt[0] - e0, 5);
        chk(ev_wide == 0 && ev_early == 0, "R1", "pulse width/timing faults", ev_wide + ev_early, 0);
        chk(wb_remain[0 +: CNT_W] == 0, "R11", "stored remain ch0", int'(wb_remain[0 +: CNT_W]), 0);
        chk(wb_addr[0 +: ADDR_W] == 'h105, "R11", "stored addr ch0", int'(wb_addr[0 +: ADDR_W]), 'h105);
    endtask

    task automatic t_burst_events();
        int e0 = evcnt[1], b0 = beats[1];
        set_desc(1, 7, 3, 'h200, 2);
        pulse_start(4'b0010); ch_req[1] = 1'b1;
        wait_off(4'b0010); ch_req[1] = 1'b0;
        chk(evcnt[1] - e0 == 3, "R3", "burst-mode pulses", evcnt[1] - e0, 3);
        chk(beats[1] - b0 == 7, "R3", "beats moved", beats[1] - b0, 7);
    endtask

    task automatic t_block_chain();
        int e0 = evcnt[0], w0 = wbcnt;
        set_desc(0, 3, 2, 'h300, 0); link[0] = 1'b1;
        pulse_start(4'b0001); ch_req[0] = 1'b1;
        set_desc(0, 2, 2, 'h400, 3);
        for (int i = 0; i < 2000 && wbcnt == w0; i++) step();
        step(); link[0] = 1'b0;
        chk(ch_en[0] == 1'b1, "R12", "enabled after linked reload", int'(ch_en[0]), 1);
        wait_off(4'b0001); ch_req[0] = 1'b0;
        chk(evcnt[0] - e0 == 1, "R4", "block pulses over chain", evcnt[0] - e0, 1);
        chk(wbcnt - w0 == 2, "R12", "write-backs over chain", wbcnt - w0, 2);
        chk(wb_addr[0 +: ADDR_W] == 'h402, "R12", "second descriptor addr", int'(wb_addr[0 +: ADDR_W]), 'h402);
    endtask

    task automatic t_evoe_gate();
        int e2 = evcnt[2], e3 = evcnt[3], b2 = beats[2], b3 = beats[3];
        ch_evoe = 4'b1011;
        set_desc(2, 3, 3, 'h500, 1); set_desc(3, 3, 3, 'h600, 1);
        pulse_start(4'b1100); ch_req = 4'b1100;
        wait_off(4'b1100); ch_req = '0; ch_evoe = '1;
        chk(evcnt[2] - e2 == 0, "R5", "pulses with enable off", evcnt[2] - e2, 0);
        chk(evcnt[3] - e3 == 0, "R5", "pulses on incapable ch", evcnt[3] - e3, 0);
        chk(beats[2] - b2 == 3 && beats[3] - b3 == 3, "R5", "beats still moved", beats[3] - b3, 3);
    endtask

    task automatic t_priority();
        nlog = 0;
        set_desc(0, 4, 2, 'h700, 0); set_desc(1, 4, 2, 'h800, 0);
        pulse_start(4'b0011); ch_req = 4'b0011;
        wait_off(4'b0011); ch_req = '0;
        chk(blog[0] == 0 && blog[1] == 0 && blog[2] == 0 && blog[3] == 0, "R6",
            "first four beats owner", blog[3], 0);
        chk(blog[4] == 1 && blog[7] == 1 && nlog == 8, "R6", "later beats owner", blog[4], 1);
    endtask

    task automatic t_abort_active();
        int e0 = evcnt[0];
        set_desc(0, 10, 10, 'h900, 1);
        pulse_start(4'b0001); ch_req[0] = 1'b1;
        wait_beats(0, beats[0] + 3);
        step(); mem_hold = 1'b1;
        ch_abort[0] = 1'b1; step(); ch_abort[0] = 1'b0;
        chk(mem_req && ch_en[0], "R8", "beat held across abort", int'(mem_req), 1);
        step(); step();
        chk(mem_req && ch_en[0], "R7", "active stays enabled mid-beat", int'(ch_en[0]), 1);
        mem_hold = 1'b0;
        for (int i = 0; i < 50 && !wb_valid; i++) step();
        chk(ch_en[0] && !mem_req, "R7", "enabled during write-back", int'(ch_en[0]), 1);
        step();
        chk(!ch_en[0], "R7", "disabled after write-back", int'(ch_en[0]), 0);
        repeat (10) step();
        ch_req[0] = 1'b0;
        chk(evcnt[0] - e0 == 4, "R7", "beats before stop", evcnt[0] - e0, 4);
        chk(wb_remain[0 +: CNT_W] == 6, "R11", "stored remain after abort", int'(wb_remain[0 +: CNT_W]), 6);
        chk(wb_addr[0 +: ADDR_W] == 'h904, "R11", "stored addr after abort", int'(wb_addr[0 +: ADDR_W]), 'h904);
    endtask

    task automatic t_abort_idle();
        set_desc(1, 4, 2, 'hA00, 0);
        pulse_start(4'b0010);
        chk(ch_en[1], "R7", "idle channel enabled", int'(ch_en[1]), 1);
        ch_abort[1] = 1'b1; step(); ch_abort[1] = 1'b0;
        chk(!ch_en[1], "R7", "idle abort next cycle", int'(ch_en[1]), 0);
    endtask

    task automatic t_global_active();
        int b0;
        set_desc(0, 10, 10, 'hB00, 0); set_desc(1, 4, 2, 'hC00, 0); set_desc(2, 4, 2, 'hD00, 0);
        pulse_start(4'b0111); ch_req[0] = 1'b1;
        wait_beats(0, beats[0] + 2);
        step(); mem_hold = 1'b1;
        ctl_disable = 1'b1; step(); ctl_disable = 1'b0;
        chk(ch_en == 4'b0001, "R9", "idle channels drop next cycle", int'(ch_en), 1);
        chk(ctl_en && mem_req, "R10", "controller held for active beat", int'(ctl_en), 1);
        ch_req = 4'b0110;
        step();
        mem_hold = 1'b0;
        for (int i = 0; i < 50 && !wb_valid; i++) step();
        chk(ch_en[0] && ctl_en, "R10", "active enabled in write-back", int'(ctl_en), 1);
        step();
        chk(ch_en == '0 && !ctl_en, "R10", "all off after write-back", int'(ctl_en), 0);
        b0 = beats[0] + beats[1] + beats[2];
        repeat (10) step();
        chk(beats[0] + beats[1] + beats[2] == b0, "R9", "no beat after disable",
            beats[0] + beats[1] + beats[2], b0);
        chk(wb_remain[0 +: CNT_W] == 7, "R11", "stored remain after disable", int'(wb_remain[0 +: CNT_W]), 7);
        ch_req = '0;
    endtask

    task automatic t_global_idle();
        pulse_ctl_en();
        set_desc(1, 4, 2, 'hE00, 0);
        pulse_start(4'b0010);
        ctl_disable = 1'b1; step(); ctl_disable = 1'b0;
        chk(!ctl_en && ch_en == '0, "R10", "idle controller off next cycle", int'(ctl_en), 0);
        pulse_start(4'b0010);
        chk(ch_en == '0, "R10", "start ignored while off", int'(ch_en), 0);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        pulse_ctl_en();
        t_beat_events();
        t_burst_events();
        t_block_chain();
        t_evoe_gate();
        t_priority();
        t_abort_active();
        t_abort_idle();
        t_global_active();
        t_global_idle();
        summary();
        $finish;
    end
endmodule